// File: doc/BRIEF.md
# Shared RAM Host Port with Auto-Increment

This block is the host's window into the byte-wide RAM that a coprocessor shares with it. The host sees four byte registers: two that together hold a 16-bit RAM pointer, a data register that reads or writes the RAM byte the pointer selects, and a control/status register. When auto-increment is enabled, every data-register access moves the pointer forward by one. A whole code image can therefore be loaded, read back or compared through the one data register after a single pointer setup.

The control/status register starts and halts the coprocessor and selects bypass mode. Writing its doorbell bit sends the coprocessor a single-cycle pulse. It also holds two interrupt flags that the coprocessor raises and the host clears by writing ones, each flag separately. The coprocessor reaches the same RAM through its own port. That is how the liveness byte is exchanged: the coprocessor writes 0xFF to an agreed location, and the host reads it and writes it back to 0.

Host requests use a valid/ready handshake. Reads return a response on a separate valid/ready channel. Writes produce no response. Only one read response is held at a time. While that response is held and the host keeps `rsp_ready` low, `req_ready` stays low and the response does not change. A new request is accepted in the same cycle that the pending response is taken.

Top module: `sram_host_port`

## Requirements
- R1: After reset the control/status register reads 0x00, both pointer bytes read 0x00, `cop_run`, `cop_bypass` and `cop_doorbell` are low, and `host_irq` is low.
- R2: A write to select 0 sets pointer bits 7:0 and a write to select 1 sets pointer bits 15:8. Both read back unchanged, reading them does not move the pointer, and the next data access uses the new pointer. The RAM byte used is given by the low log2(RAM_DEPTH) pointer bits.
- R3: A write to select 2 stores the byte at the pointer. A read of select 2 returns the byte stored at the pointer.
- R4: With control bit 1 (auto-increment) set, every accepted data access advances the pointer by one. With it clear, the pointer does not move.
- R5: Advancing the pointer from 0xFFFF gives 0x0000.
- R6: A write to select 3 loads bit 0 (run), bit 1 (auto-increment) and bit 2 (bypass). These bits read back, and `cop_run` and `cop_bypass` follow them from the next cycle.
- R7: A select-3 write with bit 3 set makes `cop_doorbell` high for exactly the cycle after the write. Bit 3 always reads as 0.
- R8: A pulse on `cop_set_int0` or `cop_set_int1` sets flag bit 4 or bit 5. `host_irq` is the OR of the two flags. Writing 1 to a flag bit clears only that flag. If a set and a clear of the same flag arrive in the same cycle, the set wins.
- R9: Bytes written through the coprocessor port can be read by the host, and host writes appear on `cop_rdata`. If both ports write the same byte in the same cycle, the host value is stored.
- R10: While a read response is held with `rsp_ready` low, `rsp_valid` stays high, `rsp_data` stays stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control/status |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 8 | Read response data |
| cop_we | input | 1 | Coprocessor RAM write enable |
| cop_addr | input | RAM_AW | Coprocessor RAM address |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor read data (combinational) |
| cop_set_int0 | input | 1 | Coprocessor raises interrupt flag 0 |
| cop_set_int1 | input | 1 | Coprocessor raises interrupt flag 1 |
| cop_run | output | 1 | Run enable to the coprocessor |
| cop_bypass | output | 1 | Bypass mode select |
| cop_doorbell | output | 1 | Single-cycle doorbell pulse |
| host_irq | output | 1 | OR of the two interrupt flags |

## Verification
The bench fills the whole RAM by streaming through the data register and then reads every byte back. A pointer that skips, repeats or fails to advance shows up as a byte mismatch. It also loads the pointer at 0xFFFF: a counter that carried into a seventeenth bit, or did not wrap, would read back a nonzero pointer. The clear-on-write flags are tested one at a time and together with a set in the same cycle: a design that cleared both flags, or let the clear win, would lose an interrupt. A response held under back-pressure must not change or let a second request in, and same-cycle writes from both ports must leave the host's byte in RAM.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_CTRL   = 2'd3
  } hp_sel_e;

  localparam int CB_RUN    = 0;
  localparam int CB_AUTOINC = 1;
  localparam int CB_BYPASS = 2;
  localparam int CB_BELL   = 3;
  localparam int CB_INT0   = 4;
  localparam int NUM_INT   = 2;
endpackage

// File: rtl/hp_addr_ctr.sv
module hp_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W/8-1:0] ld_byte,
  input  logic [7:0]        wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam int NBYTES = ADDR_W / 8;

  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt = addr;
    if (step) nxt = addr + ADDR_W'(1);
    for (int b = 0; b < NBYTES; b++) begin
      if (ld_byte[b]) nxt[8*b +: 8] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr <= '0;
    else        addr <= nxt;
  end
endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
  import hp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wdata,
  input  logic [NUM_INT-1:0] set_int,
  output logic               run,
  output logic               autoinc,
  output logic               bypass,
  output logic               bell,
  output logic [NUM_INT-1:0] int_flag,
  output logic [7:0]         status
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      autoinc <= 1'b0;
      bypass  <= 1'b0;
      bell    <= 1'b0;
    end else begin
      bell <= wr_en && wdata[CB_BELL];
      if (wr_en) begin
        run     <= wdata[CB_RUN];
        autoinc <= wdata[CB_AUTOINC];
        bypass  <= wdata[CB_BYPASS];
      end
    end
  end

  for (genvar i = 0; i < NUM_INT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                            int_flag[i] <= 1'b0;
      else if (set_int[i])                   int_flag[i] <= 1'b1;
      else if (wr_en && wdata[CB_INT0 + i])  int_flag[i] <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[CB_RUN]     = run;
    status[CB_AUTOINC] = autoinc;
    status[CB_BYPASS]  = bypass;
    status[CB_INT0 +: NUM_INT] = int_flag;
  end
endmodule

// File: rtl/hp_shared_ram.sv
module hp_shared_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          c_we,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_wdata,
  output logic [7:0]    c_rdata
);
  logic [7:0] mem [DEPTH];

  // Host write is applied last so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (c_we) mem[c_addr] <= c_wdata;
    if (h_we) mem[h_addr] <= h_wdata;
  end

  assign h_rdata = mem[h_addr];
  assign c_rdata = mem[c_addr];
endmodule

// File: rtl/sram_host_port.sv
module sram_host_port
  import hp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RAM_DEPTH = 256,
  parameter int RAM_AW    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  input  logic              cop_we,
  input  logic [RAM_AW-1:0] cop_addr,
  input  logic [7:0]        cop_wdata,
  output logic [7:0]        cop_rdata,
  input  logic              cop_set_int0,
  input  logic              cop_set_int1,
  output logic              cop_run,
  output logic              cop_bypass,
  output logic              cop_doorbell,
  output logic              host_irq
);
  localparam int NBYTES = ADDR_W / 8;

  hp_sel_e               sel;
  logic                  acc, acc_wr, acc_rd, data_acc;
  logic [NBYTES-1:0]     ld_byte;
  logic [ADDR_W-1:0]     cur_addr;
  logic                  autoinc;
  logic [NUM_INT-1:0]    int_flag;
  logic [7:0]            status, ram_rd, rd_mux;

  assign sel      = hp_sel_e'(req_sel);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc      = req_valid && req_ready;
  assign acc_wr   = acc && req_write;
  assign acc_rd   = acc && !req_write;
  assign data_acc = acc && (sel == SEL_DATA);

  assign ld_byte[0] = acc_wr && (sel == SEL_PTR_LO);
  assign ld_byte[1] = acc_wr && (sel == SEL_PTR_HI);

  hp_addr_ctr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_byte (ld_byte),
    .wdata   (req_wdata),
    .step    (data_acc && autoinc),
    .addr    (cur_addr)
  );

  hp_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_wr && (sel == SEL_CTRL)),
    .wdata    (req_wdata),
    .set_int  ({cop_set_int1, cop_set_int0}),
    .run      (cop_run),
    .autoinc  (autoinc),
    .bypass   (cop_bypass),
    .bell     (cop_doorbell),
    .int_flag (int_flag),
    .status   (status)
  );

  hp_shared_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk     (clk),
    .h_we    (acc_wr && (sel == SEL_DATA)),
    .h_addr  (cur_addr[RAM_AW-1:0]),
    .h_wdata (req_wdata),
    .h_rdata (ram_rd),
    .c_we    (cop_we),
    .c_addr  (cop_addr),
    .c_wdata (cop_wdata),
    .c_rdata (cop_rdata)
  );

  assign host_irq = |int_flag;

  always_comb begin
    unique case (sel)
      SEL_PTR_LO: rd_mux = cur_addr[7:0];
      SEL_PTR_HI: rd_mux = cur_addr[15:8];
      SEL_DATA:   rd_mux = ram_rd;
      default:    rd_mux = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hp_port_chk.sv
module hp_port_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_sel,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              cop_run,
  input logic              cop_doorbell,
  input logic              cop_set_int0,
  input logic              cop_set_int1,
  input logic              host_irq,
  input logic [ADDR_W-1:0] cur_addr
);
  logic ctrl_wr;
  assign ctrl_wr = req_valid && req_ready && req_write && (req_sel == 2'd3);

  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_bell_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cop_doorbell) |-> $past(ctrl_wr && req_wdata[3]));

  p_run_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cop_run == $past(req_wdata[0])));

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_set_int0 || cop_set_int1) |=> host_irq);

  p_ptr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(cur_addr));
endmodule

bind sram_host_port hp_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_sel      (req_sel),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .cop_run      (cop_run),
  .cop_doorbell (cop_doorbell),
  .cop_set_int0 (cop_set_int0),
  .cop_set_int1 (cop_set_int1),
  .host_irq     (host_irq),
  .cur_addr     (cur_addr)
);

// File: tb/tb_sram_host_port.sv
`timescale 1ns/1ps
module tb_sram_host_port;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_sel = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic cop_we = 1'b0;
  logic [AW-1:0] cop_addr = '0;
  logic [7:0] cop_wdata = '0, cop_rdata;
  logic cop_set_int0 = 1'b0, cop_set_int1 = 1'b0;
  logic cop_run, cop_bypass, cop_doorbell, host_irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram_host_port #(.ADDR_W(16), .RAM_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cop_we(cop_we), .cop_addr(cop_addr), .cop_wdata(cop_wdata), .cop_rdata(cop_rdata),
    .cop_set_int0(cop_set_int0), .cop_set_int1(cop_set_int1),
    .cop_run(cop_run), .cop_bypass(cop_bypass), .cop_doorbell(cop_doorbell),
    .host_irq(host_irq)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = s; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = s;
    @(posedge clk); #1;
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic rd_chk(input logic [1:0] s, input int exp, input string tag);
    logic [7:0] v;
    rd(s, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 run", cop_run, 0);
    check("R1 bypass", cop_bypass, 0);
    check("R1 doorbell", cop_doorbell, 0);
    check("R1 irq", host_irq, 0);
    rd_chk(2'd3, 8'h00, "R1 ctrl");
    rd_chk(2'd0, 8'h00, "R1 ptr lo");
    rd_chk(2'd1, 8'h00, "R1 ptr hi");

    // R3/R4 full streaming sweep with auto-increment
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    for (int i = 0; i < DEPTH; i++) wr(2'd2, pat(i));
    rd_chk(2'd0, 8'h00, "R4 ptr lo after sweep");
    rd_chk(2'd1, 8'h01, "R4 ptr hi after sweep");
    wr(2'd1, 8'h00);
    for (int i = 0; i < DEPTH; i++) rd_chk(2'd2, pat(i), "R3 stream read");

    // R2 pointer bytes
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    rd_chk(2'd0, 8'h34, "R2 lo readback");
    rd_chk(2'd1, 8'h12, "R2 hi readback");
    rd_chk(2'd2, pat(8'h34), "R2 data at new ptr");
    rd_chk(2'd0, 8'h35, "R4 advance after read");

    // R4 no auto-increment
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h10); wr(2'd1, 8'h00);
    rd_chk(2'd2, pat(8'h10), "R4 hold read1");
    rd_chk(2'd2, pat(8'h10), "R4 hold read2");
    wr(2'd2, 8'hAA);
    rd_chk(2'd2, 8'hAA, "R3 write then read");
    rd_chk(2'd0, 8'h10, "R4 ptr unchanged");

    // R5 wrap
    wr(2'd3, 8'h02);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    rd_chk(2'd2, pat(8'hFF), "R5 data at top");
    rd_chk(2'd0, 8'h00, "R5 lo wrapped");
    rd_chk(2'd1, 8'h00, "R5 hi wrapped");

    // R6 control bits
    wr(2'd3, 8'h07);
    check("R6 run", cop_run, 1);
    check("R6 bypass", cop_bypass, 1);
    rd_chk(2'd3, 8'h07, "R6 ctrl readback");
    wr(2'd3, 8'h03);
    check("R6 bypass off", cop_bypass, 0);

    // R7 doorbell
    check("R7 idle", cop_doorbell, 0);
    wr(2'd3, 8'h0B);
    check("R7 pulse", cop_doorbell, 1);
    @(posedge clk); #1;
    check("R7 pulse ends", cop_doorbell, 0);
    rd_chk(2'd3, 8'h03, "R7 bell reads 0");

    // R8 interrupt flags
    @(negedge clk) cop_set_int0 = 1'b1;
    @(negedge clk) cop_set_int0 = 1'b0;
    check("R8 irq int0", host_irq, 1);
    rd_chk(2'd3, 8'h13, "R8 int0 set");
    @(negedge clk) cop_set_int1 = 1'b1;
    @(negedge clk) cop_set_int1 = 1'b0;
    rd_chk(2'd3, 8'h33, "R8 both set");
    wr(2'd3, 8'h13);
    rd_chk(2'd3, 8'h23, "R8 clear int0 only");
    check("R8 irq int1 left", host_irq, 1);
    wr(2'd3, 8'h23);
    rd_chk(2'd3, 8'h03, "R8 clear int1");
    check("R8 irq low", host_irq, 0);
    // same-cycle set and clear of flag 0
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = 2'd3; req_wdata = 8'h13;
    cop_set_int0 = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; cop_set_int0 = 1'b0;
    rd_chk(2'd3, 8'h13, "R8 set wins");
    wr(2'd3, 8'h13);

    // R9 coprocessor port, liveness byte
    @(negedge clk) begin cop_we = 1'b1; cop_addr = 8'h40; cop_wdata = 8'hFF; end
    @(negedge clk) cop_we = 1'b0;
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h40); wr(2'd1, 8'h00);
    rd_chk(2'd2, 8'hFF, "R9 liveness read");
    wr(2'd2, 8'h00);
    cop_addr = 8'h40; #1;
    check("R9 host clear seen by cop", cop_rdata, 8'h00);
    wr(2'd0, 8'h50);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = 2'd2; req_wdata = 8'h11;
    cop_we = 1'b1; cop_addr = 8'h50; cop_wdata = 8'h22;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; cop_we = 1'b0;
    check("R9 host wins collision", cop_rdata, 8'h11);

    // R10 back-pressure
    wr(2'd0, 8'h20);
    rsp_ready = 1'b0;
    rd(2'd2, v);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 valid held", rsp_valid, 1);
      check("R10 ready low", req_ready, 0);
      check("R10 data stable", rsp_data, pat(8'h20));
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    check("R10 released", rsp_valid, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule